// File: doc/BRIEF.md
# Protocol controller soft-reset and event-flag registers

This block is the CPU-facing control corner of a serial protocol controller. A byte-wide bus reaches four registers. The first is a timing control register. Its top bit is a software reset. The other three are an event flag register that clears when read, an interrupt mask, and a watchdog register. The software reset holds the rest of the controller in reset and flushes its FIFOs. It leaves the reset bit itself and the watchdog register alone. Software must write the reset bit as zero twice in a row before the controller runs again.

The transmitter, the receiver and the FIFOs signal events with single-cycle pulses. Each pulse latches a flag. Reading the flag register returns the flags and clears every one of them. A pulse that arrives in the same cycle as that read is still kept. The interrupt output is high while any flag is set whose mask bit is also set.

Top module: `pc_ctrl_flags`

## Requirements
- R1: Register addresses are: 0 timing control, 1 event flags (read only; writes there are ignored), 2 interrupt mask, 3 watchdog. Timing control bits, MSB first, are: bit 7 software reset, bit 6 internal timing select, bit 5 C-channel enable, bit 4 clock-rate select, bits 3:0 slot select. Bits 6:0 of a write with bit 7 = 0 made outside software reset appear on `timing_cfg_o` and read back at address 0 from the next cycle.
- R2: A write to address 0 with bit 7 = 1 raises `core_rst_o` from the next cycle. While the reset bit is set, the timing bits, the mask and the flags read as 0, and writes to the mask are ignored.
- R3: Each write to address 0 with bit 7 = 1 produces a pulse on `fifo_flush_o` that is exactly one cycle long, in the cycle after the write.
- R4: The software reset leaves the watchdog register unchanged. The watchdog register also stays writable while the software reset is active, and its value is shown on `wdog_o`.
- R5: Software reset ends only on the second write to address 0 with bit 7 = 0. After the first such write, `core_rst_o` stays high and address 0 reads 0x80. The releasing write leaves the timing bits at 0.
- R6: A write with bit 7 = 1 made while in software reset restarts the count, so two more zero writes are needed.
- R7: An event pulse on `evt_i[n]` sets flag bit n, and the flag stays set until it is read. Bits, MSB first: 7 go-ahead seen, 6 end of packet seen, 5 transmit done, 4 frame abort, 3 transmit FIFO at 4/19 full, 2 transmit underrun, 1 receive FIFO at 15/19 full, 0 receive overflow.
- R8: Reading address 1 returns the flags and clears all of them. A flag sets again only on a new event, so a second read returns 0.
- R9: An event pulse in the same cycle as a read of address 1 is not returned by that read. It is latched and is returned by the next read.
- R10: `irq_o` is high exactly when some flag bit and the same mask bit are both 1.
- R11: The hardware reset `rst_n` (active low) clears every register, including the reset bit, the exit count and the watchdog register.
- R12: Event pulses that arrive while the software reset is active are not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_addr | input | ADDR_W (2) | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data, valid in the strobe cycle |
| evt_i | input | DATA_W (8) | Event pulses, one bit per flag |
| timing_cfg_o | output | DATA_W-1 (7) | Timing control bits 6:0 |
| core_rst_o | output | 1 | Held reset for the datapath |
| fifo_flush_o | output | 1 | One-cycle FIFO flush pulse |
| wdog_o | output | DATA_W (8) | Watchdog register value |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 2-bit address and an exit count of two zero writes. With these values a single write can move the exit count through each of its states. This makes the counter restart from any step directly reachable, as is the single-write state that still holds reset. The eight-bit flag width lets single events, combined events and event/mask overlaps each be tried from the vector table.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  // bit positions inside the timing control register
  localparam int unsigned CTRL_RST_BIT = 7;

  // flag bit positions (MSB first order is behaviour seen by software)
  localparam int unsigned FLG_GO_AHEAD = 7;
  localparam int unsigned FLG_EOP      = 6;
  localparam int unsigned FLG_TX_DONE  = 5;
  localparam int unsigned FLG_ABORT    = 4;
  localparam int unsigned FLG_TX_LVL   = 3;
  localparam int unsigned FLG_TX_URUN  = 2;
  localparam int unsigned FLG_RX_LVL   = 1;
  localparam int unsigned FLG_RX_OFLW  = 0;

  // true when this zero write is the one that releases the soft reset
  function automatic logic exit_due(input int unsigned seen, input int unsigned need);
    return (seen + 1) >= need;
  endfunction

  // masked interrupt reduction
  function automatic logic irq_any(input logic [7:0] flags, input logic [7:0] mask);
    return |(flags & mask);
  endfunction
endpackage

// File: rtl/pcr_bus_dec.sv
module pcr_bus_dec #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned A_CTRL = 0,
  parameter int unsigned A_FLAG = 1,
  parameter int unsigned A_MASK = 2,
  parameter int unsigned A_WDOG = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] ctrl_val,
  input  logic [DATA_W-1:0] flag_val,
  input  logic [DATA_W-1:0] mask_val,
  input  logic [DATA_W-1:0] wdog_val,
  output logic              wr_ctrl,
  output logic              wr_mask,
  output logic              wr_wdog,
  output logic              rd_flag,
  output logic [DATA_W-1:0] rdata
);
  logic hit_ctrl, hit_flag, hit_mask, hit_wdog;

  assign hit_ctrl = (addr == ADDR_W'(A_CTRL));
  assign hit_flag = (addr == ADDR_W'(A_FLAG));
  assign hit_mask = (addr == ADDR_W'(A_MASK));
  assign hit_wdog = (addr == ADDR_W'(A_WDOG));

  assign wr_ctrl = wr & hit_ctrl;
  assign wr_mask = wr & hit_mask;
  assign wr_wdog = wr & hit_wdog;
  assign rd_flag = rd & hit_flag;

  always_comb begin
    rdata = '0;
    if (hit_ctrl) rdata = ctrl_val;
    if (hit_flag) rdata = flag_val;
    if (hit_mask) rdata = mask_val;
    if (hit_wdog) rdata = wdog_val;
  end

  always_comb begin
    assert ($onehot0({wr_ctrl, wr_mask, wr_wdog}))
      else $error("a_r1_one_write_target");
  end
endmodule

// File: rtl/pcr_srst_seq.sv
module pcr_srst_seq
  import pcr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned EXIT_WRITES = 2,
  localparam int unsigned CNT_W      = $clog2(EXIT_WRITES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic              rst_bit,
  output logic              hold,
  output logic              flush,
  output logic [DATA_W-2:0] cfg
);
  logic             rst_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flush_q;
  logic [DATA_W-2:0] cfg_q;
  logic             set_req;
  logic             zero_req;
  logic             release_now;

  assign set_req     = wr_ctrl & wdata[CTRL_RST_BIT];
  assign zero_req    = wr_ctrl & ~wdata[CTRL_RST_BIT];
  assign release_now = zero_req & rst_q & exit_due(32'(cnt_q), EXIT_WRITES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= set_req;
      if (set_req) begin
        rst_q <= 1'b1;
        cnt_q <= '0;
      end else if (zero_req && rst_q) begin
        if (release_now) begin
          rst_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (rst_q || set_req) cfg_q <= '0;
    else if (zero_req) cfg_q <= wdata[DATA_W-2:0];
  end

  assign rst_bit = rst_q;
  assign hold    = rst_q | set_req;
  assign flush   = flush_q;
  assign cfg     = cfg_q;

  a_r5_exit_on_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> $past(wr_ctrl && !wdata[CTRL_RST_BIT]));
  a_r6_set_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CTRL_RST_BIT]) |=> (rst_q && cnt_q == '0));
  a_r3_flush_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> rst_q);
  a_r2_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (cfg_q == '0));
endmodule

// File: rtl/pcr_evt_flags.sv
module pcr_evt_flags #(
  parameter int unsigned NFLAG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             clr,
  input  logic [NFLAG-1:0] evt,
  output logic [NFLAG-1:0] flags
);
  logic [NFLAG-1:0] flags_q;

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q[i] <= 1'b0;
        else if (hold) flags_q[i] <= 1'b0;
        else flags_q[i] <= (flags_q[i] & ~clr) | evt[i];
      end
    end
  endgenerate

  assign flags = flags_q;

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> (flags_q == '0));
  a_r9_same_cycle_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hold) |=> ((flags_q & $past(evt)) == $past(evt)));
  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !hold) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  a_r12_no_latch_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (flags_q == '0));
endmodule

// File: rtl/pc_ctrl_flags.sv
module pc_ctrl_flags
  import pcr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned EXIT_WRITES = 2,
  parameter int unsigned A_CTRL      = 0,
  parameter int unsigned A_FLAG      = 1,
  parameter int unsigned A_MASK      = 2,
  parameter int unsigned A_WDOG      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] evt_i,
  output logic [DATA_W-2:0] timing_cfg_o,
  output logic              core_rst_o,
  output logic              fifo_flush_o,
  output logic [DATA_W-1:0] wdog_o,
  output logic              irq_o
);
  logic              wr_ctrl, wr_mask, wr_wdog, rd_flag;
  logic              rst_bit, hold, flush;
  logic [DATA_W-2:0] cfg;
  logic [DATA_W-1:0] flags;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] wdog_q;
  logic [DATA_W-1:0] ctrl_val;

  pcr_bus_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .A_CTRL(A_CTRL), .A_FLAG(A_FLAG), .A_MASK(A_MASK), .A_WDOG(A_WDOG)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .ctrl_val(ctrl_val), .flag_val(flags), .mask_val(mask_q), .wdog_val(wdog_q),
    .wr_ctrl(wr_ctrl), .wr_mask(wr_mask), .wr_wdog(wr_wdog), .rd_flag(rd_flag),
    .rdata(bus_rdata)
  );

  pcr_srst_seq #(.DATA_W(DATA_W), .EXIT_WRITES(EXIT_WRITES)) u_srst (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .rst_bit(rst_bit), .hold(hold), .flush(flush), .cfg(cfg)
  );

  pcr_evt_flags #(.NFLAG(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .hold(hold), .clr(rd_flag), .evt(evt_i),
    .flags(flags)
  );

  // mask: cleared by either reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (hold) mask_q <= '0;
    else if (wr_mask) mask_q <= bus_wdata;
  end

  // watchdog register: only the hardware reset touches it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdog_q <= '0;
    else if (wr_wdog) wdog_q <= bus_wdata;
  end

  assign ctrl_val     = {rst_bit, cfg};
  assign timing_cfg_o = cfg;
  assign core_rst_o   = rst_bit;
  assign fifo_flush_o = flush;
  assign wdog_o       = wdog_q;
  assign irq_o        = irq_any(flags, mask_q);

  a_r4_wdog_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_bit && !wr_wdog) |=> $stable(wdog_q));
  a_r2_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit |-> (mask_q == '0));
endmodule

// File: tb/pc_ctrl_flags_bench.sv
module pc_ctrl_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] evt_i = '0;
  logic [6:0] timing_cfg_o;
  logic       core_rst_o, fifo_flush_o, irq_o;
  logic [7:0] wdog_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pc_ctrl_flags u_pc_ctrl_flags (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .timing_cfg_o(timing_cfg_o), .core_rst_o(core_rst_o), .fifo_flush_o(fifo_flush_o),
    .wdog_o(wdog_o), .irq_o(irq_o)
  );

  // event pattern (high byte) and mask (low byte)
  localparam logic [15:0] VEC [0:7] = '{
    16'h80_80, 16'h40_00, 16'h21_01, 16'h0C_F0,
    16'h02_02, 16'hFF_00, 16'h10_EF, 16'hA5_5A
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    bread(2'd0, rd); chk("R11 ctrl after hw reset", rd, 8'h00);
    bread(2'd1, rd); chk("R11 flags after hw reset", rd, 8'h00);
    chk("R11 wdog after hw reset", wdog_o, 8'h00);
    chk("R11 core_rst after hw reset", {7'd0, core_rst_o}, 8'h00);

    // R1 timing bits
    bwrite(2'd0, 8'h5A);
    chk("R1 timing_cfg_o", {1'b0, timing_cfg_o}, 8'h5A);
    bread(2'd0, rd); chk("R1 ctrl readback", rd, 8'h5A);

    // vector table: R7 R8 R10
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ev, mk;
      ev = VEC[i][15:8]; mk = VEC[i][7:0];
      bwrite(2'd2, mk);
      pulse(ev);
      chk("R10 irq", {7'd0, irq_o}, {7'd0, |(ev & mk)});
      bread(2'd1, rd); chk("R7 flags latched", rd, ev);
      chk("R8 irq after read", {7'd0, irq_o}, 8'h00);
      bread(2'd1, rd); chk("R8 second read", rd, 8'h00);
    end

    // R9 event during read
    pulse(8'h80);
    @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1'b1; evt_i = 8'h11;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; evt_i = '0;
    chk("R9 read returns old", rd, 8'h80);
    bread(2'd1, rd); chk("R9 event kept", rd, 8'h11);

    // R2 R3 R4 soft reset
    bwrite(2'd3, 8'h3C);
    bwrite(2'd2, 8'hFF);
    pulse(8'h04);
    bwrite(2'd0, 8'h8F);
    chk("R3 flush pulse", {7'd0, fifo_flush_o}, 8'h01);
    chk("R2 core_rst high", {7'd0, core_rst_o}, 8'h01);
    @(negedge clk);
    chk("R3 flush one cycle", {7'd0, fifo_flush_o}, 8'h00);
    bread(2'd0, rd); chk("R2 ctrl in reset", rd, 8'h80);
    bread(2'd2, rd); chk("R2 mask cleared", rd, 8'h00);
    chk("R2 irq low", {7'd0, irq_o}, 8'h00);
    chk("R4 wdog kept", wdog_o, 8'h3C);
    bwrite(2'd2, 8'hFF);
    bread(2'd2, rd); chk("R2 mask write ignored", rd, 8'h00);
    bwrite(2'd3, 8'hC3);
    chk("R4 wdog writable in reset", wdog_o, 8'hC3);
    pulse(8'hFF);

    // R5 R6 exit sequence
    bwrite(2'd0, 8'h00);
    chk("R5 still in reset after one", {7'd0, core_rst_o}, 8'h01);
    bread(2'd0, rd); chk("R5 ctrl after one", rd, 8'h80);
    bwrite(2'd0, 8'h80);
    chk("R3 flush on re-set", {7'd0, fifo_flush_o}, 8'h01);
    bwrite(2'd0, 8'h00);
    chk("R6 restart holds", {7'd0, core_rst_o}, 8'h01);
    bwrite(2'd0, 8'h7F);
    chk("R5 released", {7'd0, core_rst_o}, 8'h00);
    bread(2'd0, rd); chk("R5 timing bits zero", rd, 8'h00);
    bread(2'd1, rd); chk("R12 events dropped", rd, 8'h00);
    bwrite(2'd1, 8'hFF);
    bread(2'd1, rd); chk("R1 flag write ignored", rd, 8'h00);

    // R11 hardware reset mid-run
    bwrite(2'd0, 8'h80);
    pulse(8'h00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R11 reset bit cleared", {7'd0, core_rst_o}, 8'h00);
    chk("R11 wdog cleared", wdog_o, 8'h00);
    bwrite(2'd0, 8'h80);
    bwrite(2'd0, 8'h00);
    chk("R11 count cleared", {7'd0, core_rst_o}, 8'h01);

    done = 1;
    summary();
  end
endmodule